// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block terminates inbound message-signalled interrupt writes. Each write carries an address that names one pending register and a data value that names one bit inside it. The block holds 2048 vectors. They are split into 16 groups. Each group has 8 pending registers, and each register holds 16 vector bits. Every group drives one level interrupt line to a downstream interrupt controller.

A processor services a line through a 32-bit read port. It first reads the group's summary word to learn which pending registers are non-empty. It then reads each of those registers. Reading a pending register returns its bits and clears it in the same access. The interrupt line falls once nothing is left pending in its group. A vector written in the same cycle as a clearing read of its register is kept, so no interrupt is lost.

Top module: `msi_term_bank`

## Requirements
- R1: A write with `wr_data` d in 0..15 to address (n<<19)+(x<<16), with n in 0..15 and x in 0..7, sets bit d of pending register x of group n. Address bits [15:0] are ignored.
- R2: A read of a pending register returns its 16 bits on `rd_data[15:0]`, with bits [31:16] zero. Data and `rd_valid` appear one cycle after `rd_en`.
- R3: Reading a pending register clears it. A second read with no write in between returns zero.
- R4: The summary word of group n sits at 0x800000+(n<<16). Its bit x is 1 exactly when pending register x of group n is non-zero, and bits [31:8] read zero. Reading it changes no state.
- R5: `irq[n]` is high exactly when group n holds any pending bit. It rises in the cycle after the write edge and falls in the cycle after the clearing read of the last non-empty register.
- R6: If a write sets a bit in the same cycle that a read clears the same register, that read returns the old contents and the new bit stays pending for the next read.
- R7: A write with `wr_data` of 16 or more is ignored, as is a write to any address of 0x800000 or above.
- R8: A read of any address of 0x900000 or above returns zero and changes no state.
- R9: Synchronous reset clears every pending bit, every `irq` line and `rd_valid`.
- R10: Vector v is stored in group v mod 16, register v / 256, bit (v / 16) mod 16.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Inbound interrupt write strobe |
| wr_addr | input | 24 | Inbound write byte address |
| wr_data | input | 32 | Inbound write data (vector bit number) |
| rd_en | input | 1 | Processor read strobe |
| rd_addr | input | 24 | Processor read byte address |
| rd_data | output | 32 | Read result, registered |
| rd_valid | output | 1 | High in the cycle `rd_data` is valid |
| irq | output | 16 | Per-group level interrupt |

## Verification
The bench walks a table of vector numbers that includes the first and last vectors. For each one it checks that the vector lands in the right group, register and bit. A design with the mapping fields swapped would raise the wrong line or report the wrong summary bit. Directed tests cover a write that collides with a clearing read of the same register; a design that lets the clear win would silently drop that vector. Further tests cover out-of-range data values and writes into the summary region, which a design that decodes too loosely would turn into stray pending bits. The bench also checks that unmapped and summary reads leave state untouched, which catches a clear that fires on the wrong decode. Last, it checks that reset applied mid-run wipes pending state.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  localparam int GROUPS   = 16;
  localparam int IDX_PER  = 8;
  localparam int VEC_BITS = 16;
  localparam int ADDR_W   = 24;
  localparam int DATA_W   = 32;
  localparam int PAGE_LSB = 16;
  localparam int GRP_W    = $clog2(GROUPS);
  localparam int IDX_W    = $clog2(IDX_PER);
  localparam int BIT_W    = $clog2(VEC_BITS);
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;
  localparam int SUM_PAGE = GROUPS * IDX_PER;
endpackage

// File: rtl/msi_addr_dec.sv
module msi_addr_dec
  import msi_term_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_idx,
  output logic              hit_sum,
  output logic [GRP_W-1:0]  grp,
  output logic [IDX_W-1:0]  idx,
  output logic [GRP_W-1:0]  sum_grp
);
  logic [PAGE_W-1:0] page;
  logic              unused_low;

  assign page       = addr[ADDR_W-1:PAGE_LSB];
  assign unused_low = ^addr[PAGE_LSB-1:0];

  always_comb begin
    hit_idx = (int'(page) < SUM_PAGE);
    hit_sum = (int'(page) >= SUM_PAGE) && (int'(page) < SUM_PAGE + GROUPS);
    idx     = page[IDX_W-1:0];
    grp     = page[IDX_W +: GRP_W];
    sum_grp = GRP_W'(page - PAGE_W'(SUM_PAGE));
  end
endmodule

// File: rtl/msi_group.sv
module msi_group
  import msi_term_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_en,
  input  logic [IDX_W-1:0]          set_idx,
  input  logic [BIT_W-1:0]          set_bit,
  input  logic                      clr_en,
  input  logic [IDX_W-1:0]          clr_idx,
  output logic [IDX_PER*VEC_BITS-1:0] pend_flat,
  output logic [IDX_PER-1:0]        summary,
  output logic                      irq
);
  logic [IDX_PER-1:0] nxt_any;

  for (genvar i = 0; i < IDX_PER; i++) begin : g_reg
    logic [VEC_BITS-1:0] q;
    logic [VEC_BITS-1:0] nxt;

    always_comb begin
      nxt = (clr_en && clr_idx == IDX_W'(i)) ? '0 : q;
      if (set_en && set_idx == IDX_W'(i))
        nxt[set_bit] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
    end

    assign pend_flat[i*VEC_BITS +: VEC_BITS] = q;
    assign summary[i] = |q;
    assign nxt_any[i] = |nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |nxt_any;
  end
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [23:0]       wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [23:0]       rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic [15:0]       irq
);
  logic             w_idx, w_sum_unused;
  logic [GRP_W-1:0] w_grp, w_sgrp_unused;
  logic [IDX_W-1:0] w_reg;
  logic             r_idx, r_sum;
  logic [GRP_W-1:0] r_grp, r_sgrp;
  logic [IDX_W-1:0] r_reg;
  logic             wr_ok;
  logic [BIT_W-1:0] wr_bit;
  logic [DATA_W-1:0] rd_word;

  logic [IDX_PER*VEC_BITS-1:0] gp [GROUPS];
  logic [IDX_PER-1:0]          gs [GROUPS];

  msi_addr_dec u_wdec (
    .addr(wr_addr), .hit_idx(w_idx), .hit_sum(w_sum_unused),
    .grp(w_grp), .idx(w_reg), .sum_grp(w_sgrp_unused)
  );

  msi_addr_dec u_rdec (
    .addr(rd_addr), .hit_idx(r_idx), .hit_sum(r_sum),
    .grp(r_grp), .idx(r_reg), .sum_grp(r_sgrp)
  );

  assign wr_ok  = wr_en && w_idx && (wr_data < DATA_W'(VEC_BITS));
  assign wr_bit = wr_data[BIT_W-1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    msi_group u_grp (
      .clk      (clk),
      .rst      (rst),
      .set_en   (wr_ok && w_grp == GRP_W'(g)),
      .set_idx  (w_reg),
      .set_bit  (wr_bit),
      .clr_en   (rd_en && r_idx && r_grp == GRP_W'(g)),
      .clr_idx  (r_reg),
      .pend_flat(gp[g]),
      .summary  (gs[g]),
      .irq      (irq[g])
    );
  end

  always_comb begin
    rd_word = '0;
    if (r_idx)
      rd_word[VEC_BITS-1:0] = gp[r_grp][r_reg*VEC_BITS +: VEC_BITS];
    else if (r_sum)
      rd_word[IDX_PER-1:0] = gs[r_sgrp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/msi_term_chk.sv
module msi_term_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [23:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        rd_en,
  input logic [23:0] rd_addr,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic [15:0] irq
);
  // R2
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R5
  irq_rise_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(irq)) != 16'h0) |-> $past(wr_en));

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr >= 24'h900000) |=> (rd_data == 32'h0));

  // R4
  summary_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr >= 24'h800000 && !wr_en) |=> (irq == $past(irq)));

  // R7
  bad_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data >= 32'd16 || wr_addr >= 24'h800000) && !rd_en)
      |=> (irq == $past(irq)));

  // R2
  index_read_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr < 24'h800000) |=> (rd_data[31:16] == 16'h0));
endmodule

bind msi_term_bank msi_term_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
  .irq(irq)
);

// File: tb/sim_msi_term_bank.sv
module sim_msi_term_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [15:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  msi_term_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq(irq)
  );

  localparam int NV = 8;
  localparam int VEC_TBL [NV] = '{0, 1, 17, 256, 300, 1000, 1555, 2047};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] idx_addr(input int g, input int x, input int lo);
    return 24'((g << 19) + (x << 16) + lo);
  endfunction

  function automatic logic [23:0] sum_addr(input int g);
    return 24'(32'h800000 + (g << 16));
  endfunction

  task automatic do_write(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    check(rd_valid === 1'b1, "R2 rd_valid", 32'(rd_valid), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(irq === 16'h0, "R9 irq after reset", 32'(irq), 32'h0);
    check(rd_valid === 1'b0, "R9 rd_valid after reset", 32'(rd_valid), 32'h0);

    // R10 R1 R4 R5 R3 table walk
    for (int k = 0; k < NV; k++) begin
      int v = VEC_TBL[k];
      int g = v % 16;
      int b = (v / 16) % 16;
      int x = v / 256;
      do_write(idx_addr(g, x, (v * 4) & 16'hFFFF), 32'(b));
      check(irq === 16'(1 << g), "R10 R5 irq line", 32'(irq), 32'(1 << g));
      do_read(sum_addr(g), d);
      check(d === 32'(1 << x), "R4 summary bit", d, 32'(1 << x));
      do_read(idx_addr(g, x, 0), d);
      check(d === 32'(1 << b), "R1 R2 index bits", d, 32'(1 << b));
      check(irq === 16'h0, "R5 irq drops after clear", 32'(irq), 32'h0);
      do_read(idx_addr(g, x, 0), d);
      check(d === 32'h0, "R3 cleared", d, 32'h0);
    end

    // R1 two bits, two registers in one group; R5 stays high until last read
    do_write(idx_addr(3, 2, 0), 32'd3);
    do_write(idx_addr(3, 2, 16'h1234), 32'd9);
    do_write(idx_addr(3, 6, 0), 32'd15);
    do_read(sum_addr(3), d);
    check(d === 32'h44, "R4 summary two regs", d, 32'h44);
    do_read(sum_addr(3), d);
    check(d === 32'h44, "R4 summary read has no side effect", d, 32'h44);
    do_read(idx_addr(3, 2, 0), d);
    check(d === 32'h0208, "R1 two bits", d, 32'h0208);
    check(irq[3] === 1'b1, "R5 irq held by other reg", 32'(irq[3]), 32'h1);
    do_read(idx_addr(3, 6, 0), d);
    check(d === 32'h8000, "R1 bit 15", d, 32'h8000);
    check(irq[3] === 1'b0, "R5 irq falls at last clear", 32'(irq[3]), 32'h0);

    // R6 collision: write and clearing read of the same register in one cycle
    do_write(idx_addr(9, 4, 0), 32'd1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = idx_addr(9, 4, 0); wr_data = 32'd7;
    rd_en = 1'b1; rd_addr = idx_addr(9, 4, 0);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rd_data === 32'h0002, "R6 read returns old bits", rd_data, 32'h0002);
    check(irq[9] === 1'b1, "R6 irq stays", 32'(irq[9]), 32'h1);
    do_read(idx_addr(9, 4, 0), d);
    check(d === 32'h0080, "R6 new bit survives", d, 32'h0080);

    // R7 ignored writes
    do_write(idx_addr(5, 0, 0), 32'd16);
    do_write(idx_addr(5, 0, 0), 32'hFFFF_0003);
    do_write(24'h800000, 32'd1);
    do_write(24'hF00000, 32'd2);
    check(irq === 16'h0, "R7 no irq from bad writes", 32'(irq), 32'h0);
    do_read(idx_addr(5, 0, 0), d);
    check(d === 32'h0, "R7 register untouched", d, 32'h0);
    do_read(sum_addr(0), d);
    check(d === 32'h0, "R7 summary untouched", d, 32'h0);

    // R8 unmapped reads
    do_write(idx_addr(12, 1, 0), 32'd4);
    do_read(24'h900000, d);
    check(d === 32'h0, "R8 unmapped zero", d, 32'h0);
    do_read(24'hFF0000, d);
    check(d === 32'h0, "R8 unmapped top zero", d, 32'h0);
    check(irq[12] === 1'b1, "R8 irq untouched", 32'(irq[12]), 32'h1);
    do_read(idx_addr(12, 1, 0), d);
    check(d === 32'h0010, "R8 state untouched", d, 32'h0010);

    // R9 reset mid-run
    do_write(idx_addr(7, 3, 0), 32'd2);
    do_write(idx_addr(14, 0, 0), 32'd11);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(irq === 16'h0, "R9 irq cleared by reset", 32'(irq), 32'h0);
    do_read(idx_addr(7, 3, 0), d);
    check(d === 32'h0, "R9 pending cleared by reset", d, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule